// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Sequencer

This block sits on the host side of a byte-wide parallel NOR flash bus. A client hands it one request at a time over a valid/ready handshake: an operation code, a target address and a data byte. The sequencer turns the request into the unlock and command write cycles the flash expects. It drives the address, data, chip-enable, write-enable and output-enable lines with strobe widths counted in clock cycles. It then waits for the flash's internal operation to finish and reports one response, which is either success or a timeout error.

Four operations are supported: byte program, sector erase, whole-chip erase and the exit from identification mode. The client picks the completion method for each request. Toggle-bit polling reads the target byte in pairs until bit 6 stops changing. Data-complement polling reads the target byte until bit 7 equals the true value. A fixed wait counts a set number of clocks sized for the worst case. Polling is limited by a per-operation clock budget, so a flash that never finishes cannot hang the client.

Top module: `flash_pe_seq`

## Requirements
- R1: While reset is asserted and after it is released, chip-enable, write-enable and output-enable are high (inactive), the data bus is not driven, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A byte program (`req_op`=0) writes, in order, AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the request data at the request address.
- R3: A sector erase (`req_op`=1) writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and then 30h at the request address, in that order.
- R4: A chip erase (`req_op`=2) writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and 10h@5555h, in that order.
- R5: An identification exit (`req_op`=3) writes AAh@5555h, 55h@2AAAh and F0h@5555h. It performs no reads, whatever `req_wait` holds, and it responds without error exactly WE_HIGH+1+ID_RECOV clocks after the last write-enable rising edge.
- R6: In every write cycle, write-enable is low for exactly WE_LOW clocks while chip-enable is low and the bus is driven. Address and data stay unchanged through the rising edge of write-enable and are still driven in the clock after it.
- R7: With `req_wait`=0 (toggle), the target address is read in pairs. The request completes without error after the first pair whose two reads return the same bit 6.
- R8: With `req_wait`=1 (data polling), the target address is read until bit 7 equals the true data bit 7. That bit is the request data for a program and 1 for an erase. A response without error follows that read.
- R9: With `req_wait`=2 or 3 (fixed wait), no read is issued. The response comes without error exactly WE_HIGH+1+F clocks after the last write-enable rising edge, where F is PROG_FIXED for a program and ERASE_FIXED for either erase.
- R10: If polling has not completed once PROG_LIMIT (program) or ERASE_LIMIT (erase) clocks have passed since the last command write, the next unsuccessful poll ends the request with `rsp_err`=1.
- R11: `req_ready` drops in the clock after a request is accepted and returns only after the single-cycle `rsp_valid` pulse. A request presented while busy is ignored and produces no bus write.
- R12: Each poll read holds output-enable and chip-enable low for exactly RD_LOW clocks, with write-enable high and the data bus released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 identification exit |
| req_wait | input | 2 | 0 toggle polling, 1 data polling, 2 or 3 fixed wait |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a timeout (valid with rsp_valid) |
| flash_addr | output | AW | Flash address bus |
| flash_dq_o | output | 8 | Data driven to the flash |
| flash_dq_oe | output | 1 | Data bus drive enable |
| flash_dq_i | input | 8 | Data read from the flash |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
Bus-pin results are judged in the clock they appear. The bench samples every pin on the falling edge and counts strobe widths in clocks, so a write-enable pulse must be exactly WE_LOW samples long and a read pulse exactly RD_LOW. The response time is checked only where it is fixed by design: for fixed waits and the identification exit, `rsp_valid` must arrive exactly WE_HIGH+1 plus the wait length after the last write-enable rise. For polled completions the count of reads must match the number of busy reads the flash model returns. `req_ready` is checked at the first falling edge after acceptance and on each clock of an ignored request.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [1:0] {
      OP_PROG  = 2'd0,
      OP_SECT  = 2'd1,
      OP_CHIP  = 2'd2,
      OP_IDEXT = 2'd3
   } flash_op_e;

   typedef enum logic [1:0] {
      WM_TOGGLE = 2'd0,
      WM_DPOLL  = 2'd1,
      WM_FIXED  = 2'd2,
      WM_FIXED2 = 2'd3
   } wait_mode_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_WLOW  = 2'd1,
      PH_WHIGH = 2'd2,
      PH_RLOW  = 2'd3
   } bus_phase_e;

   localparam int UNLOCK_AW = 15;
   localparam logic [UNLOCK_AW-1:0] UNLK_HI = 15'h5555;
   localparam logic [UNLOCK_AW-1:0] UNLK_LO = 15'h2AAA;

   function automatic logic [2:0] last_step(input flash_op_e op);
      case (op)
         OP_PROG:  return 3'd3;
         OP_IDEXT: return 3'd2;
         default:  return 3'd5;
      endcase
   endfunction

endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
   import flash_seq_pkg::*;
#(
   parameter int AW = 18
) (
   input  logic [1:0]    op,
   input  logic [2:0]    step,
   input  logic [AW-1:0] tgt_addr,
   input  logic [7:0]    tgt_data,
   output logic [AW-1:0] cmd_addr,
   output logic [7:0]    cmd_data,
   output logic          cmd_last
);
   localparam logic [AW-1:0] A_HI = AW'(UNLK_HI);
   localparam logic [AW-1:0] A_LO = AW'(UNLK_LO);

   flash_op_e op_e;
   assign op_e = flash_op_e'(op);

   always_comb begin
      cmd_addr = A_HI;
      cmd_data = 8'hAA;
      case (step)
         3'd1: begin cmd_addr = A_LO; cmd_data = 8'h55; end
         3'd2: begin
            cmd_addr = A_HI;
            case (op_e)
               OP_PROG:  cmd_data = 8'hA0;
               OP_IDEXT: cmd_data = 8'hF0;
               default:  cmd_data = 8'h80;
            endcase
         end
         3'd3: begin
            if (op_e == OP_PROG) begin
               cmd_addr = tgt_addr;
               cmd_data = tgt_data;
            end
         end
         3'd4: begin cmd_addr = A_LO; cmd_data = 8'h55; end
         3'd5: begin
            if (op_e == OP_CHIP) begin
               cmd_addr = A_HI;
               cmd_data = 8'h10;
            end else begin
               cmd_addr = tgt_addr;
               cmd_data = 8'h30;
            end
         end
         default: ;
      endcase
   end

   assign cmd_last = (step == last_step(op_e));

endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
   import flash_seq_pkg::*;
#(
   parameter int AW      = 18,
   parameter int WE_LOW  = 3,
   parameter int WE_HIGH = 2,
   parameter int RD_LOW  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          rd_req,
   input  logic [AW-1:0] addr_in,
   input  logic [7:0]    wdat_in,
   output logic          cyc_done,
   output logic [7:0]    rdat,
   output logic [AW-1:0] bus_addr,
   output logic [7:0]    bus_dq_o,
   output logic          bus_dq_oe,
   input  logic [7:0]    bus_dq_i,
   output logic          bus_ce_n,
   output logic          bus_we_n,
   output logic          bus_oe_n
);
   localparam int PMAX0 = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
   localparam int PMAX  = (PMAX0 > RD_LOW) ? PMAX0 : RD_LOW;
   localparam int CW    = (PMAX > 1) ? $clog2(PMAX) : 1;

   generate
      if (WE_LOW < 1 || WE_HIGH < 1 || RD_LOW < 1) begin : g_bad_width
         $error("flash_bus_cycle: strobe widths must be at least one clock");
      end
   endgenerate

   bus_phase_e    ph;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         cnt      <= '0;
         bus_addr <= '0;
         bus_dq_o <= '0;
         rdat     <= '0;
         cyc_done <= 1'b0;
      end else begin
         cyc_done <= 1'b0;
         case (ph)
            PH_IDLE: begin
               if (start) begin
                  bus_addr <= addr_in;
                  bus_dq_o <= wdat_in;
                  cnt      <= '0;
                  ph       <= rd_req ? PH_RLOW : PH_WLOW;
               end
            end
            PH_WLOW: begin
               if (cnt == CW'(WE_LOW - 1)) begin
                  cnt <= '0;
                  ph  <= PH_WHIGH;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_WHIGH: begin
               if (cnt == CW'(WE_HIGH - 1)) begin
                  cnt      <= '0;
                  ph       <= PH_IDLE;
                  cyc_done <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (cnt == CW'(RD_LOW - 1)) begin
                  cnt      <= '0;
                  rdat     <= bus_dq_i;
                  ph       <= PH_IDLE;
                  cyc_done <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign bus_ce_n  = (ph == PH_IDLE);
   assign bus_we_n  = (ph != PH_WLOW);
   assign bus_oe_n  = (ph != PH_RLOW);
   assign bus_dq_oe = (ph == PH_WLOW) || (ph == PH_WHIGH);

   // R6
   we_low_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we_n |-> (!bus_ce_n && bus_dq_oe));

   // R6
   we_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_we_n) |-> ($stable(bus_addr) && $stable(bus_dq_o) && bus_dq_oe));

   // R12
   rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe_n |-> (!bus_dq_oe && bus_we_n && !bus_ce_n));

   // R6
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> bus_ce_n);

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
   import flash_seq_pkg::*;
#(
   parameter int AW          = 18,
   parameter int WE_LOW      = 3,
   parameter int WE_HIGH     = 2,
   parameter int RD_LOW      = 3,
   parameter int PROG_LIMIT  = 2000,
   parameter int ERASE_LIMIT = 250_000_000,
   parameter int PROG_FIXED  = 1500,
   parameter int ERASE_FIXED = 200_000_000,
   parameter int ID_RECOV    = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [1:0]    req_op,
   input  logic [1:0]    req_wait,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_data,
   output logic          rsp_valid,
   output logic          rsp_err,
   output logic [AW-1:0] flash_addr,
   output logic [7:0]    flash_dq_o,
   output logic          flash_dq_oe,
   input  logic [7:0]    flash_dq_i,
   output logic          flash_ce_n,
   output logic          flash_we_n,
   output logic          flash_oe_n
);
   localparam int TM0  = (PROG_LIMIT > ERASE_LIMIT) ? PROG_LIMIT : ERASE_LIMIT;
   localparam int TM1  = (TM0 > ERASE_FIXED) ? TM0 : ERASE_FIXED;
   localparam int TM2  = (TM1 > PROG_FIXED) ? TM1 : PROG_FIXED;
   localparam int TMAX = (TM2 > ID_RECOV) ? TM2 : ID_RECOV;
   localparam int TCW  = $clog2(TMAX + 1);

   generate
      if (AW < UNLOCK_AW) begin : g_bad_aw
         $error("flash_pe_seq: AW must cover the unlock addresses");
      end
      if (PROG_FIXED < 1 || ERASE_FIXED < 1 || ID_RECOV < 1) begin : g_bad_fixed
         $error("flash_pe_seq: fixed waits must be at least one clock");
      end
      if (PROG_LIMIT < 1 || ERASE_LIMIT < 1) begin : g_bad_limit
         $error("flash_pe_seq: poll limits must be positive");
      end
   endgenerate

   typedef enum logic [3:0] {
      S_IDLE, S_CMD, S_CMDW, S_RD1, S_RD1W, S_RD2, S_RD2W, S_TIMER, S_RSP
   } seq_st_e;

   seq_st_e       st;
   flash_op_e     op_q;
   wait_mode_e    mode_q;
   logic [AW-1:0] addr_q;
   logic [7:0]    data_q;
   logic [2:0]    step_q;
   logic [TCW-1:0] tcnt;
   logic          dq6_q;
   logic          err_q;

   logic [AW-1:0] cmd_addr;
   logic [7:0]    cmd_data;
   logic          cmd_last;
   logic          bus_start, bus_rd, bus_done;
   logic [7:0]    bus_rdat;
   logic          rd_unused;

   flash_cmd_rom #(.AW(AW)) u_rom (
      .op       (op_q),
      .step     (step_q),
      .tgt_addr (addr_q),
      .tgt_data (data_q),
      .cmd_addr (cmd_addr),
      .cmd_data (cmd_data),
      .cmd_last (cmd_last)
   );

   assign bus_start = (st == S_CMD) || (st == S_RD1) || (st == S_RD2);
   assign bus_rd    = (st != S_CMD);

   flash_bus_cycle #(
      .AW(AW), .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RD_LOW(RD_LOW)
   ) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (bus_start),
      .rd_req    (bus_rd),
      .addr_in   (bus_rd ? addr_q : cmd_addr),
      .wdat_in   (cmd_data),
      .cyc_done  (bus_done),
      .rdat      (bus_rdat),
      .bus_addr  (flash_addr),
      .bus_dq_o  (flash_dq_o),
      .bus_dq_oe (flash_dq_oe),
      .bus_dq_i  (flash_dq_i),
      .bus_ce_n  (flash_ce_n),
      .bus_we_n  (flash_we_n),
      .bus_oe_n  (flash_oe_n)
   );

   assign rd_unused = ^bus_rdat[5:0];

   // Per-operation budgets
   logic [TCW-1:0] lim, fix_len;
   logic           true7, poll_ok, in_wait;

   always_comb begin
      lim     = (op_q == OP_PROG) ? TCW'(PROG_LIMIT) : TCW'(ERASE_LIMIT);
      fix_len = (op_q == OP_PROG)  ? TCW'(PROG_FIXED) :
                (op_q == OP_IDEXT) ? TCW'(ID_RECOV) : TCW'(ERASE_FIXED);
      true7   = (op_q == OP_PROG) ? data_q[7] : 1'b1;
      poll_ok = (mode_q == WM_DPOLL) ? (bus_rdat[7] == true7)
                                     : (bus_rdat[6] == dq6_q);
   end

   assign in_wait = (st == S_RD1) || (st == S_RD1W) || (st == S_RD2) ||
                    (st == S_RD2W) || (st == S_TIMER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         op_q   <= OP_PROG;
         mode_q <= WM_TOGGLE;
         addr_q <= '0;
         data_q <= '0;
         step_q <= '0;
         tcnt   <= '0;
         dq6_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (in_wait && (tcnt != '1)) tcnt <= tcnt + 1'b1;
         case (st)
            S_IDLE: begin
               if (req_valid) begin
                  op_q   <= flash_op_e'(req_op);
                  mode_q <= wait_mode_e'(req_wait);
                  addr_q <= req_addr;
                  data_q <= req_data;
                  step_q <= '0;
                  err_q  <= 1'b0;
                  st     <= S_CMD;
               end
            end
            S_CMD: st <= S_CMDW;
            S_CMDW: begin
               if (bus_done) begin
                  if (cmd_last) begin
                     tcnt <= '0;
                     if (op_q == OP_IDEXT || mode_q == WM_FIXED || mode_q == WM_FIXED2)
                        st <= S_TIMER;
                     else if (mode_q == WM_DPOLL)
                        st <= S_RD2;
                     else
                        st <= S_RD1;
                  end else begin
                     step_q <= step_q + 1'b1;
                     st     <= S_CMD;
                  end
               end
            end
            S_RD1: st <= S_RD1W;
            S_RD1W: begin
               if (bus_done) begin
                  dq6_q <= bus_rdat[6];
                  st    <= S_RD2;
               end
            end
            S_RD2: st <= S_RD2W;
            S_RD2W: begin
               if (bus_done) begin
                  if (poll_ok) begin
                     err_q <= 1'b0;
                     st    <= S_RSP;
                  end else if (tcnt >= lim) begin
                     err_q <= 1'b1;
                     st    <= S_RSP;
                  end else begin
                     st <= (mode_q == WM_DPOLL) ? S_RD2 : S_RD1;
                  end
               end
            end
            S_TIMER: begin
               if (tcnt >= fix_len - 1'b1) st <= S_RSP;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign req_ready = (st == S_IDLE);
   assign rsp_valid = (st == S_RSP);
   assign rsp_err   = (st == S_RSP) && err_q;

   // R11
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R11
   rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (req_ready && !rsp_valid));

   // R9
   fixed_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_TIMER) |-> (flash_oe_n && flash_we_n));

   // R10
   err_only_polled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (mode_q == WM_TOGGLE || mode_q == WM_DPOLL));

endmodule

// File: tb/tb_flash_pe_seq.sv
module tb_flash_pe_seq;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 18;
   localparam int WEL  = 3;
   localparam int WEH  = 2;
   localparam int RDL  = 2;
   localparam int PLIM = 150;
   localparam int ELIM = 300;
   localparam int PFIX = 40;
   localparam int EFIX = 60;
   localparam int IDR  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_op = '0, req_wait = '0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0] req_data = '0;
   logic req_ready, rsp_valid, rsp_err;
   logic [AW-1:0] flash_addr;
   logic [7:0] flash_dq_o, flash_dq_i;
   logic flash_dq_oe, flash_ce_n, flash_we_n, flash_oe_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_pe_seq #(
      .AW(AW), .WE_LOW(WEL), .WE_HIGH(WEH), .RD_LOW(RDL),
      .PROG_LIMIT(PLIM), .ERASE_LIMIT(ELIM), .PROG_FIXED(PFIX),
      .ERASE_FIXED(EFIX), .ID_RECOV(IDR)
   ) dut (.*);

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // flash model state
   int busy_reads = 0;
   int rd_cnt = 0;
   logic [7:0] true_byte = 8'hFF;
   logic [AW-1:0] tgt = '0;
   assign flash_dq_i = (rd_cnt < busy_reads) ?
                       {~true_byte[7], rd_cnt[0], 6'h15} : true_byte;

   // scoreboard queues
   int    wq_addr[$];
   int    wq_data[$];
   string wq_tag[$];
   int    rq_err[$];
   int    rq_reads[$];
   int    rq_elap[$];
   string rq_tag[$];
   int    rsp_seen = 0;

   task automatic push_w(input int a, input int d, input string tag);
      wq_addr.push_back(a);
      wq_data.push_back(d);
      wq_tag.push_back(tag);
   endtask

   // monitor
   int cyc = 0, we_low = 0, oe_low = 0, last_we_cyc = 0;
   logic prev_we = 1'b1, prev_oe = 1'b1;
   logic [AW-1:0] prev_addr = '0;
   logic [7:0] prev_dq = '0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (!flash_we_n) begin
            we_low++;
            chk(!flash_ce_n && flash_dq_oe, "R6", "ce/oe during we low", flash_ce_n, 0);
         end
         if (flash_we_n && !prev_we) begin
            last_we_cyc = cyc;
            chk(we_low == WEL, "R6", "we low width", we_low, WEL);
            chk(flash_addr == prev_addr && flash_dq_o == prev_dq && flash_dq_oe,
                "R6", "addr/data hold at we rise", flash_dq_o, prev_dq);
            if (wq_addr.size() == 0) begin
               chk(0, "R11", "unexpected write addr", flash_addr, 0);
            end else begin
               int ea, ed;
               string t;
               ea = wq_addr.pop_front();
               ed = wq_data.pop_front();
               t  = wq_tag.pop_front();
               chk(int'(prev_addr) == ea, t, "write address", prev_addr, ea);
               chk(int'(prev_dq) == ed, t, "write data", prev_dq, ed);
            end
            we_low = 0;
         end
         if (!flash_oe_n) begin
            oe_low++;
            if (oe_low == 1)
               chk(flash_we_n && !flash_dq_oe && !flash_ce_n, "R12",
                   "strobes during read", flash_dq_oe, 0);
         end
         if (flash_oe_n && !prev_oe) begin
            chk(oe_low == RDL, "R12", "read low width", oe_low, RDL);
            chk(prev_addr == tgt, "R7", "poll read address", prev_addr, tgt);
            rd_cnt++;
            oe_low = 0;
         end
         if (rsp_valid) begin
            if (rq_err.size() == 0) begin
               chk(0, "R11", "unexpected response", 1, 0);
            end else begin
               int ee, er, el;
               string t;
               ee = rq_err.pop_front();
               er = rq_reads.pop_front();
               el = rq_elap.pop_front();
               t  = rq_tag.pop_front();
               chk(rsp_err == ee[0], t, "rsp_err", rsp_err, ee);
               if (er >= 0) chk(rd_cnt == er, t, "poll read count", rd_cnt, er);
               if (el >= 0) chk(cyc - last_we_cyc == el, t, "response latency",
                                cyc - last_we_cyc, el);
               chk(wq_addr.size() == 0, t, "writes left at response", wq_addr.size(), 0);
            end
            rd_cnt = 0;
            rsp_seen++;
         end
         prev_addr = flash_addr;
         prev_dq   = flash_dq_o;
      end
      prev_we = flash_we_n;
      prev_oe = flash_oe_n;
   end

   // driver
   task automatic run_op(input int op, input int mode, input int addr, input int data,
                         input int busy, input int eerr, input int ereads,
                         input int eelap, input string tag);
      int seen;
      push_w(16'h5555, 8'hAA, tag);
      push_w(16'h2AAA, 8'h55, tag);
      case (op)
         0: begin push_w(16'h5555, 8'hA0, tag); push_w(addr, data, tag); end
         1: begin
            push_w(16'h5555, 8'h80, tag); push_w(16'h5555, 8'hAA, tag);
            push_w(16'h2AAA, 8'h55, tag); push_w(addr, 8'h30, tag);
         end
         2: begin
            push_w(16'h5555, 8'h80, tag); push_w(16'h5555, 8'hAA, tag);
            push_w(16'h2AAA, 8'h55, tag); push_w(16'h5555, 8'h10, tag);
         end
         default: push_w(16'h5555, 8'hF0, tag);
      endcase
      rq_err.push_back(eerr);
      rq_reads.push_back(ereads);
      rq_elap.push_back(eelap);
      rq_tag.push_back(tag);
      busy_reads = busy;
      true_byte  = (op == 0) ? data[7:0] : 8'hFF;
      tgt        = AW'(addr);
      seen       = rsp_seen;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_op    = op[1:0];
      req_wait  = mode[1:0];
      req_addr  = AW'(addr);
      req_data  = data[7:0];
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R11", "ready after accept", req_ready, 0);
      while (rsp_seen == seen) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe, "R1",
          "strobes in reset", {flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe}, 4'hE);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(req_ready && !rsp_valid, "R1", "ready after reset", req_ready, 1);
      chk(flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe, "R1",
          "strobes after reset", {flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe}, 4'hE);

      // R2 + R7: program, toggle, 4 busy reads -> 6 reads
      run_op(0, 0, 18'h12345, 8'h3C, 4, 0, 6, -1, "R2");
      // R8: program, data polling, bit7 = 1, 3 busy reads -> 4 reads
      run_op(0, 1, 18'h00101, 8'hC5, 3, 0, 4, -1, "R8");
      // R3 + R7: sector erase, toggle
      run_op(1, 0, 18'h21000, 8'h00, 2, 0, 4, -1, "R3");
      // R4 + R8: chip erase, data polling
      run_op(2, 1, 18'h00007, 8'h00, 5, 0, 6, -1, "R4");
      // R7: chip erase, already finished -> one pair
      run_op(2, 0, 18'h3FFFF, 8'h00, 0, 0, 2, -1, "R7");
      // R9: program and sector erase with fixed wait
      run_op(0, 2, 18'h0ABCD, 8'h5A, 1000, 0, 0, WEH + 1 + PFIX, "R9");
      run_op(1, 3, 18'h10000, 8'h00, 1000, 0, 0, WEH + 1 + EFIX, "R9");
      // R5: identification exit ignores poll mode
      run_op(3, 0, 18'h00000, 8'h00, 1000, 0, 0, WEH + 1 + IDR, "R5");
      // R10: never-finishing program and erase
      run_op(0, 0, 18'h00222, 8'h81, 100000, 1, -1, -1, "R10");
      run_op(1, 1, 18'h04000, 8'h00, 100000, 1, -1, -1, "R10");

      // R11: request while busy is ignored
      fork
         run_op(0, 1, 18'h00333, 8'h11, 6, 0, 7, -1, "R11");
         begin
            repeat (4) @(negedge clk);
            for (int i = 0; i < 6; i++) begin
               req_valid = 1'b1;
               req_op    = 2'd2;
               chk(!req_ready, "R11", "ready while busy", req_ready, 0);
               @(negedge clk);
            end
            req_valid = 1'b0;
         end
      join
      repeat (40) @(negedge clk);
      chk(wq_addr.size() == 0 && flash_ce_n, "R11", "no write from ignored request",
          wq_addr.size(), 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule